// File: doc/BRIEF.md
# Modulo Address Pointer Update Unit

This block is the pointer arithmetic of an address generator for a signal-processing datapath. It holds a small file of 16-bit pointer registers. Every cycle one pointer is selected. Its current value is presented at once as the effective address. The unit also computes a post-updated value: the pointer plus one, minus one, plus a signed 16-bit offset, or the pointer unchanged. When the update strobe is high, that value is written back to the selected register on the rising clock edge.

The two lowest-numbered pointers can address a circular buffer. A single shared modulus register holds the buffer length minus one. The buffer base is found by clearing the low k bits of the pointer, where 2^k is the smallest power of two at or above the buffer length. A step that passes the top of the buffer, or falls below its base, is corrected by exactly one buffer length.

A modulus of all ones turns circular addressing off. The remaining pointers always step linearly, modulo 2^16. A load strobe writes a given value into the selected pointer, and a second strobe loads the modulus register.

Top module: `modptr_unit`

## Requirements
- R1: A synchronous reset clears every pointer to 0 and sets the modulus register to 0xFFFF.
- R2: `eff_addr` always equals the selected pointer before any update. With `upd_en` high and `ld_en` low, `next_ptr` is written to the selected pointer on the rising edge.
- R3: Pointers 2 and 3 always step linearly, modulo 2^16. The step is chosen by `op`: 2'b01 adds 1, 2'b10 subtracts 1, 2'b11 adds the two's-complement `offset`, and 2'b00 holds the value.
- R4: While the modulus register holds 0xFFFF, pointers 0 and 1 also step linearly.
- R5: For pointers 0 and 1 with modulus M not equal to 0xFFFF, the buffer base is the pointer with its low k bits cleared (2^k is the smallest power of two at or above M+1). The top is base+M. A non-negative step whose sum exceeds the top has M+1 subtracted from it.
- R6: A negative step whose sum falls below the base has M+1 added to it.
- R7: Only one correction is ever applied. An offset larger than the buffer can leave the result outside the buffer.
- R8: A pointer already above its buffer top is still forced through the modulo rule. For example, pointer 6 with M=5 and an offset of 0 gives 0.
- R9: The hold op (2'b00) leaves the pointer unchanged and applies no modulo correction, even to a pointer that lies outside its buffer.
- R10: With `upd_en` and `ld_en` both low, no pointer changes. `ld_en` writes `ld_data` to the selected pointer and takes priority over `upd_en`.
- R11: `mod_ld_en` loads `mod_ld_data` into the modulus register. The new value first governs the next cycle's arithmetic.
- R12: With M=0 (a one-entry buffer), incrementing or decrementing pointers 0 and 1 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ptr_sel | input | 2 | Index of the selected pointer |
| op | input | 2 | Step kind: 00 hold, 01 +1, 10 -1, 11 +offset |
| offset | input | 16 | Signed step used when op is 11 |
| upd_en | input | 1 | Write the post-updated value back |
| ld_en | input | 1 | Load `ld_data` into the selected pointer |
| ld_data | input | 16 | Pointer load value |
| mod_ld_en | input | 1 | Load the modulus register |
| mod_ld_data | input | 16 | Modulus load value (length minus one) |
| eff_addr | output | 16 | Selected pointer before update |
| next_ptr | output | 16 | Computed post-update pointer |

## Verification
The bench targets the wrap points of a 37-entry buffer that is not a power-of-two length, based at 0x0080. It steps forward off the top at 0x00A4 and backward off the base. A design that derived the base from the modulus instead of the pointer, or that used a power-of-two size, would land on the wrong address there. It also drives an oversized offset and an out-of-buffer pointer with a zero offset. A design that corrected twice, or that passed the out-of-range pointer through unchanged, would differ from the expected single-wrap values 0x00CB and 0. The hold op, the one-entry buffer, load priority over update and 16-bit linear rollover complete the corners, with a randomised phase compared against a behavioural model every cycle.

// File: rtl/modptr_pkg.sv
package modptr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_INC  = 2'b01,
        OP_DEC  = 2'b10,
        OP_ADDN = 2'b11
    } step_op_e;

    typedef enum logic [1:0] {
        MODE_NOUPD  = 2'b00,
        MODE_LINEAR = 2'b01,
        MODE_MODULO = 2'b10
    } upd_mode_e;

endpackage

// File: rtl/modptr_bounds.sv
module modptr_bounds #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] mod_val,
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] lower,
    output logic [ADDR_W:0]   upper
);
    logic [ADDR_W-1:0] mask;

    // mask bit i is set when any modulus bit at or above i is set:
    // this yields 2^k - 1 with 2^k the smallest power of two >= mod_val + 1
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign mask[i] = |mod_val[ADDR_W-1:i];
    end

    assign lower = ptr & ~mask;
    assign upper = {1'b0, lower} + {1'b0, mod_val};

endmodule

// File: rtl/modptr_adder.sv
module modptr_adder
    import modptr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  upd_mode_e         mode,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] step,
    input  logic [ADDR_W-1:0] mod_val,
    input  logic [ADDR_W-1:0] lower,
    input  logic [ADDR_W:0]   upper,
    output logic [ADDR_W-1:0] nxt
);
    localparam int W2 = ADDR_W + 2;

    logic signed [W2-1:0] sum_s;
    logic signed [W2-1:0] lo_s;
    logic signed [W2-1:0] hi_s;
    logic signed [W2-1:0] size_s;
    logic                 backward;

    assign backward = step[ADDR_W-1];
    assign sum_s    = $signed({2'b00, ptr}) + $signed({{2{step[ADDR_W-1]}}, step});
    assign lo_s     = $signed({2'b00, lower});
    assign hi_s     = $signed({1'b0, upper});
    assign size_s   = $signed({2'b00, mod_val} + W2'(1));

    always_comb begin
        nxt = ptr;
        unique case (mode)
            MODE_NOUPD:  nxt = ptr;
            MODE_LINEAR: nxt = sum_s[ADDR_W-1:0];
            MODE_MODULO: begin
                if (!backward && (sum_s > hi_s))
                    nxt = ADDR_W'(sum_s - size_s);
                else if (backward && (sum_s < lo_s))
                    nxt = ADDR_W'(sum_s + size_s);
                else
                    nxt = sum_s[ADDR_W-1:0];
            end
            default:     nxt = ptr;
        endcase
    end

endmodule

// File: rtl/modptr_regs.sv
module modptr_regs #(
    parameter int NUM_PTR = 4,
    parameter int ADDR_W  = 16,
    localparam int SEL_W  = $clog2(NUM_PTR)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [ADDR_W-1:0]              wr_data,
    input  logic [SEL_W-1:0]               rd_sel,
    output logic [ADDR_W-1:0]              rd_data,
    output logic [NUM_PTR-1:0][ADDR_W-1:0] regs
);
    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(i)))
                regs[i] <= wr_data;
        end
    end

    assign rd_data = regs[rd_sel];

endmodule

// File: rtl/modptr_unit.sv
module modptr_unit
    import modptr_pkg::*;
#(
    parameter int NUM_PTR = 4,
    parameter int NUM_MOD = 2,
    parameter int ADDR_W  = 16,
    localparam int SEL_W  = $clog2(NUM_PTR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  ptr_sel,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] offset,
    input  logic              upd_en,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_data,
    input  logic              mod_ld_en,
    input  logic [ADDR_W-1:0] mod_ld_data,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] next_ptr
);
    logic [ADDR_W-1:0]              mod_q;
    logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0]              lower_b;
    logic [ADDR_W:0]                upper_b;
    logic [ADDR_W-1:0]              step;
    logic [ADDR_W-1:0]              wr_data;
    logic                           modulo_ok;
    step_op_e                       op_e;
    upd_mode_e                      mode;

    always_ff @(posedge clk) begin
        if (rst)
            mod_q <= '1;
        else if (mod_ld_en)
            mod_q <= mod_ld_data;
    end

    assign op_e      = step_op_e'(op);
    assign modulo_ok = (ptr_sel < SEL_W'(NUM_MOD)) && !(&mod_q);

    always_comb begin
        step = '0;
        unique case (op_e)
            OP_HOLD: step = '0;
            OP_INC:  step = ADDR_W'(1);
            OP_DEC:  step = '1;
            OP_ADDN: step = offset;
            default: step = '0;
        endcase
    end

    always_comb begin
        mode = MODE_NOUPD;
        unique case (op_e)
            OP_HOLD: mode = MODE_NOUPD;
            default: mode = modulo_ok ? MODE_MODULO : MODE_LINEAR;
        endcase
    end

    modptr_regs #(.NUM_PTR(NUM_PTR), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (upd_en | ld_en),
        .wr_sel  (ptr_sel),
        .wr_data (wr_data),
        .rd_sel  (ptr_sel),
        .rd_data (eff_addr),
        .regs    (ptr_q)
    );

    modptr_bounds #(.ADDR_W(ADDR_W)) u_bounds (
        .mod_val (mod_q),
        .ptr     (eff_addr),
        .lower   (lower_b),
        .upper   (upper_b)
    );

    modptr_adder #(.ADDR_W(ADDR_W)) u_adder (
        .mode    (mode),
        .ptr     (eff_addr),
        .step    (step),
        .mod_val (mod_q),
        .lower   (lower_b),
        .upper   (upper_b),
        .nxt     (next_ptr)
    );

    assign wr_data = ld_en ? ld_data : next_ptr;

endmodule

// File: rtl/modptr_chk.sv
module modptr_chk #(
    parameter int NUM_PTR = 4,
    parameter int NUM_MOD = 2,
    parameter int ADDR_W  = 16,
    localparam int SEL_W  = $clog2(NUM_PTR)
) (
    input logic                           clk,
    input logic                           rst,
    input logic [SEL_W-1:0]               ptr_sel,
    input logic [1:0]                     op,
    input logic                           upd_en,
    input logic                           ld_en,
    input logic [ADDR_W-1:0]              eff_addr,
    input logic [ADDR_W-1:0]              next_ptr,
    input logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q,
    input logic [ADDR_W-1:0]              mod_q,
    input logic [ADDR_W-1:0]              lower_b,
    input logic [ADDR_W:0]                upper_b
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((ptr_q == '0) && (&mod_q)));

    assert_writeback_R2: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !ld_en) |=> (ptr_q[$past(ptr_sel)] == $past(next_ptr)));

    assert_linear_inc_R3: assert property (@(posedge clk) disable iff (rst)
        ((ptr_sel >= SEL_W'(NUM_MOD)) && (op == 2'b01)) |-> (next_ptr == ADDR_W'(eff_addr + 1'b1)));

    assert_in_buffer_R5: assert property (@(posedge clk) disable iff (rst)
        ((ptr_sel < SEL_W'(NUM_MOD)) && !(&mod_q) && ((op == 2'b01) || (op == 2'b10))
         && ({1'b0, eff_addr} <= upper_b))
        |-> ((next_ptr >= lower_b) && ({1'b0, next_ptr} <= upper_b)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (op == 2'b00) |-> (next_ptr == eff_addr));

    assert_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !ld_en) |=> $stable(ptr_q));

endmodule

bind modptr_unit modptr_chk #(
    .NUM_PTR (NUM_PTR),
    .NUM_MOD (NUM_MOD),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ptr_sel  (ptr_sel),
    .op       (op),
    .upd_en   (upd_en),
    .ld_en    (ld_en),
    .eff_addr (eff_addr),
    .next_ptr (next_ptr),
    .ptr_q    (ptr_q),
    .mod_q    (mod_q),
    .lower_b  (lower_b),
    .upper_b  (upper_b)
);

// File: tb/sim_modptr_unit.sv
`timescale 1ns/1ps
module sim_modptr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ptr_sel = '0;
    logic [1:0]  op = '0;
    logic [15:0] offset = '0;
    logic        upd_en = 1'b0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_data = '0;
    logic        mod_ld_en = 1'b0;
    logic [15:0] mod_ld_data = '0;
    logic [15:0] eff_addr;
    logic [15:0] next_ptr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int ptr_m [4];
    int mod_m;

    always #2.5 clk = ~clk;

    modptr_unit u0 (
        .clk(clk), .rst(rst), .ptr_sel(ptr_sel), .op(op), .offset(offset),
        .upd_en(upd_en), .ld_en(ld_en), .ld_data(ld_data),
        .mod_ld_en(mod_ld_en), .mod_ld_data(mod_ld_data),
        .eff_addr(eff_addr), .next_ptr(next_ptr)
    );

    function automatic int model_next(int p, int sel, logic [1:0] o, logic [15:0] n, int m);
        int stp, sz, k, lo, hi, s;
        if (o == 2'b00) return p;
        stp = (o == 2'b01) ? 1 : (o == 2'b10) ? -1 : int'($signed(n));
        s = p + stp;
        if (sel < 2 && m != 32'hFFFF) begin
            sz = m + 1;
            k = 0;
            while ((1 << k) < sz) k++;
            lo = p - (p % (1 << k));
            hi = lo + m;
            if (stp >= 0 && s > hi) s = s - sz;
            else if (stp < 0 && s < lo) s = s + sz;
        end
        return s & 32'hFFFF;
    endfunction

    task automatic check16(string tag, logic [15:0] act, int exp);
        n_cmp++;
        if (act !== exp[15:0]) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp[15:0]);
        end
    endtask

    task automatic cyc(string tag, logic [1:0] sel, logic [1:0] o, logic [15:0] n,
                       bit u, bit l, logic [15:0] ld, bit ml, logic [15:0] mld);
        int exp_nxt;
        @(negedge clk);
        ptr_sel = sel; op = o; offset = n; upd_en = u; ld_en = l; ld_data = ld;
        mod_ld_en = ml; mod_ld_data = mld;
        #1;
        exp_nxt = model_next(ptr_m[sel], sel, o, n, mod_m);
        check16({tag, " eff_addr"}, eff_addr, ptr_m[sel]);
        check16({tag, " next_ptr"}, next_ptr, exp_nxt);
        @(posedge clk);
        if (ml) mod_m = mld;
        if (l) ptr_m[sel] = ld;
        else if (u) ptr_m[sel] = exp_nxt;
    endtask

    task automatic peek(string tag, logic [1:0] sel, int exp);
        @(negedge clk);
        ptr_sel = sel; op = 2'b00; upd_en = 0; ld_en = 0; mod_ld_en = 0;
        #1;
        check16(tag, eff_addr, exp);
    endtask

    task automatic setmod(int m);
        cyc("R11 mod load", 2'd2, 2'b00, 16'h0, 0, 0, 16'h0, 1, m[15:0]);
    endtask

    task automatic setptr(logic [1:0] sel, int v);
        cyc("R10 ptr load", sel, 2'b00, 16'h0, 0, 1, v[15:0], 0, 16'h0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) ptr_m[i] = 0;
        mod_m = 32'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: every pointer reads zero after reset
        for (int i = 0; i < 4; i++) peek("R1 reset ptr", 2'(i), 0);
        // R4: modulus all ones after reset, pointer 0 steps linearly
        cyc("R4 linear ptr0", 2'd0, 2'b11, 16'h1234, 1, 0, 0, 0, 0);
        peek("R4 ptr0 after add", 2'd0, 16'h1234);
        cyc("R2 eff is pre-update", 2'd0, 2'b01, 16'h0, 1, 0, 0, 0, 0);
        peek("R2 written", 2'd0, 16'h1235);
        // R11 / R10: 37-entry buffer, load wins over update
        setmod(36);
        cyc("R10 load over update", 2'd0, 2'b01, 16'h0, 1, 1, 16'h00A3, 0, 0);
        peek("R10 load priority", 2'd0, 16'h00A3);
        // R5: forward wrap at top 0x00A4
        cyc("R5 inc to top", 2'd0, 2'b01, 16'h0, 1, 0, 0, 0, 0);
        peek("R5 at top", 2'd0, 16'h00A4);
        cyc("R5 wrap forward", 2'd0, 2'b01, 16'h0, 1, 0, 0, 0, 0);
        peek("R5 wrapped to base", 2'd0, 16'h0080);
        // R6: backward wrap
        cyc("R6 wrap backward", 2'd0, 2'b10, 16'h0, 1, 0, 0, 0, 0);
        peek("R6 wrapped to top", 2'd0, 16'h00A4);
        // R7: oversized offset, single correction only
        setptr(2'd0, 16'h00A0);
        cyc("R7 big offset", 2'd0, 2'b11, 16'd80, 1, 0, 0, 0, 0);
        peek("R7 single wrap", 2'd0, 16'h00CB);
        // R9: hold leaves out-of-buffer pointer alone
        cyc("R9 hold", 2'd0, 2'b00, 16'h0, 1, 0, 0, 0, 0);
        peek("R9 unchanged", 2'd0, 16'h00CB);
        // R8: pointer 6, M=5, offset 0 -> 0
        setmod(5);
        setptr(2'd1, 6);
        cyc("R8 out of buffer", 2'd1, 2'b11, 16'h0, 1, 0, 0, 0, 0);
        peek("R8 forced wrap", 2'd1, 0);
        // R12: one-entry buffer
        setmod(0);
        setptr(2'd1, 16'h0055);
        cyc("R12 inc", 2'd1, 2'b01, 16'h0, 1, 0, 0, 0, 0);
        cyc("R12 dec", 2'd1, 2'b10, 16'h0, 1, 0, 0, 0, 0);
        peek("R12 unchanged", 2'd1, 16'h0055);
        // R3: linear rollover on pointers 2 and 3
        setptr(2'd2, 16'hFFFF);
        cyc("R3 inc rollover", 2'd2, 2'b01, 16'h0, 1, 0, 0, 0, 0);
        peek("R3 rolled to 0", 2'd2, 0);
        cyc("R3 dec rollover", 2'd3, 2'b10, 16'h0, 1, 0, 0, 0, 0);
        peek("R3 rolled to ffff", 2'd3, 16'hFFFF);
        cyc("R3 negative offset", 2'd2, 2'b11, 16'hFFFD, 1, 0, 0, 0, 0);
        peek("R3 minus three", 2'd2, 16'hFFFD);
        // R10: no strobe, no change
        cyc("R10 idle", 2'd2, 2'b01, 16'h0, 0, 0, 0, 0, 0);
        peek("R10 idle unchanged", 2'd2, 16'hFFFD);
        // R4: disable modulo again
        setmod(32'hFFFF);
        setptr(2'd0, 16'h00A4);
        cyc("R4 linear past old top", 2'd0, 2'b01, 16'h0, 1, 0, 0, 0, 0);
        peek("R4 linear result", 2'd0, 16'h00A5);
        // randomised phase, compared every cycle (R2 R3 R5 R6 R7)
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r == 0)
                setmod($urandom_range(0, 3) == 0 ? 32'hFFFF : $urandom_range(0, 70));
            else if (r == 1)
                setptr(2'($urandom_range(0, 3)), $urandom_range(0, 16'hFFFF));
            else
                cyc("R2 random", 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    16'($signed($urandom_range(0, 80)) - 40),
                    $urandom_range(0, 3) != 0, 0, 0, 0, 0);
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule